// File: doc/BRIEF.md
# Muxed Two-Stage Module Clock Generator

This block produces a peripheral clock from one of four source clocks. All sources share a single reference clock, and each source appears as a one-cycle tick enable in that clock domain. The chosen source first passes through a power-of-two pre-divider (by 1, 2, 4 or 8). A second divider then divides by a value from 1 to 16. The result leaves the block in two forms: a one-cycle clock-enable pulse that closes every output period, and a level waveform that shows the duty cycle.

Software writes one 32-bit control word to enable the output, pick the source and set both divide factors. The output rate is the source rate shifted right by P, then divided by M+1. The block can only divide, never multiply. A setting written while the output runs waits until the current output period has ended, so no short period or runt pulse can appear. Clearing the enable stops the output at once and holds both counters at zero.

Top module: `clkgen_modclk`

## Requirements
- R1: After synchronous reset, rd_data reads 0, and out_ce and out_lvl are low.
- R2: The control word has the enable at bit 31, the source select at bits 25:24, P at bits 17:16 and M at bits 3:0. Reads return the last written word with every other bit forced to zero. Writing all ones therefore reads back 0x8303000F.
- R3: While the enable bit is 0, out_ce and out_lvl stay low whatever the source ticks do.
- R4: Select value k (0 to 3) makes src_tick[k] the counted source. The other sources have no effect.
- R5: The pre-divider emits one tick for every 2^P ticks of the selected source.
- R6: An output period lasts M+1 pre-divided ticks. out_ce is high in the cycle of the source tick that completes each period, so consecutive out_ce pulses are (M+1)·2^P source ticks apart.
- R7: out_lvl is high for the first floor((M+1)/2) pre-divided ticks of each period and low for the rest. When M=0 it is held high.
- R8: New select, P or M values written while enabled take effect only after the running period completes. That period keeps its old length.
- R9: On enable, both counters start from zero. The first out_ce comes a full period after the enable is written, even if the block was disabled part-way through an earlier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes wr_data into the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, unused bits zero |
| src_tick | input | 4 | One tick enable per source clock |
| out_ce | output | 1 | One-cycle pulse ending each output period |
| out_lvl | output | 1 | Output clock level (duty waveform) |

## Verification
A write is captured at a rising edge. rd_data shows the new word at the next falling-edge sample, and the counters start from zero in the cycle after that edge. out_ce is combinational from the tick that closes a period, so the bench samples it on the falling edge of that same cycle. With the always-ticking source 0 selected, the first pulse after an enable falls exactly (M+1)·2^P samples after the write, counting the first cycle after the capturing edge as one. Slower sources tick at a phase the bench does not control, so their results are checked only as the distance between two consecutive pulses. Duty results are counted over the samples of the one full period that follows a pulse.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int REG_W   = 32;
    localparam int NSRC    = 4;
    localparam int SEL_W   = $clog2(NSRC);
    localparam int P_W     = 2;
    localparam int M_W     = 4;
    localparam int PCNT_W  = (1 << P_W) - 1;

    localparam int EN_BIT  = 31;
    localparam int SEL_LSB = 24;
    localparam int P_LSB   = 16;
    localparam int M_LSB   = 0;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [P_W-1:0]   p;
        logic [M_W-1:0]   m;
    } div_set_t;

    typedef struct packed {
        logic     en;
        div_set_t set;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
        ctl_t c;
        c.en      = w[EN_BIT];
        c.set.sel = w[SEL_LSB +: SEL_W];
        c.set.p   = w[P_LSB +: P_W];
        c.set.m   = w[M_LSB +: M_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
        logic [REG_W-1:0] w;
        w                    = '0;
        w[EN_BIT]            = c.en;
        w[SEL_LSB +: SEL_W]  = c.set.sel;
        w[P_LSB +: P_W]      = c.set.p;
        w[M_LSB +: M_W]      = c.set.m;
        return w;
    endfunction

    // Terminal count of the pre-divider: 2^p - 1
    function automatic logic [PCNT_W-1:0] pre_limit(input logic [P_W-1:0] p);
        logic [PCNT_W-1:0] r;
        r = '0;
        for (int i = 0; i < PCNT_W; i++) begin
            if (i < int'(p)) r[i] = 1'b1;
        end
        return r;
    endfunction

    // Number of pre-divided ticks the level stays high; at least one
    function automatic logic [M_W:0] high_len(input logic [M_W-1:0] m);
        logic [M_W:0] n;
        logic [M_W:0] h;
        n = {1'b0, m} + 1'b1;
        h = n >> 1;
        if (h == '0) h = 1;
        return h;
    endfunction

endpackage

// File: rtl/clkgen_ctl_reg.sv
module clkgen_ctl_reg
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl_q,
    output ctl_t             ctl_nxt,
    output logic [REG_W-1:0] rd_data
);

    localparam logic [REG_W-1:0] RD_MASK = ctl_pack('1);

    always_comb begin
        ctl_nxt = wr_en ? ctl_unpack(wr_data) : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_nxt;
    end

    assign rd_data = ctl_pack(ctl_q);

    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & RD_MASK)));

endmodule

// File: rtl/clkgen_prediv.sv
module clkgen_prediv
    import clkgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [P_W-1:0]   p,
    output logic             pre_tick
);

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;
    logic              tick;

    assign lim      = pre_limit(p);
    assign tick     = src_tick[sel];
    assign pre_tick = run && tick && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)  pcnt <= '0;
        else if (tick)    pcnt <= pre_tick ? '0 : pcnt + 1'b1;
    end

    assert_pre_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (pcnt <= lim));

endmodule

// File: rtl/clkgen_postdiv.sv
module clkgen_postdiv
    import clkgen_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           pre_tick,
    input  logic [M_W-1:0] m,
    output logic           wrap,
    output logic           lvl
);

    logic [M_W-1:0] mcnt;

    assign wrap = run && pre_tick && (mcnt == m);
    assign lvl  = run && ({1'b0, mcnt} < high_len(m));

    always_ff @(posedge clk) begin
        if (rst || !run)   mcnt <= '0;
        else if (pre_tick) mcnt <= (mcnt == m) ? '0 : mcnt + 1'b1;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> (mcnt <= m));

    assert_lvl_start_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (!run || lvl));

endmodule

// File: rtl/clkgen_modclk.sv
module clkgen_modclk
    import clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [3:0]  src_tick,
    output logic        out_ce,
    output logic        out_lvl
);

    ctl_t     ctl_q;
    ctl_t     ctl_nxt;
    div_set_t act;
    logic     run;
    logic     pre_tick;
    logic     wrap;
    logic     lvl;

    clkgen_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .ctl_nxt (ctl_nxt),
        .rd_data (rd_data)
    );

    assign run = ctl_q.en;

    // Active settings: follow the control word while stopped,
    // otherwise refresh only at a period boundary.
    always_ff @(posedge clk) begin
        if (rst)       act <= '0;
        else if (!run) act <= ctl_nxt.set;
        else if (wrap) act <= ctl_q.set;
    end

    clkgen_prediv u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .src_tick (src_tick),
        .sel      (act.sel),
        .p        (act.p),
        .pre_tick (pre_tick)
    );

    clkgen_postdiv u_post (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .pre_tick (pre_tick),
        .m        (act.m),
        .wrap     (wrap),
        .lvl      (lvl)
    );

    assign out_ce  = wrap;
    assign out_lvl = lvl;

    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!out_ce && !out_lvl));

    assert_hold_set_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(act));

endmodule

// File: tb/sim_clkgen_modclk.sv
`timescale 1ns/1ps
module sim_clkgen_modclk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_tick = '0;
    logic        out_ce;
    logic        out_lvl;

    int n_chk = 0;
    int n_bad = 0;
    int fc = 0;

    always #4 clk = ~clk;

    clkgen_modclk u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .src_tick (src_tick),
        .out_ce   (out_ce),
        .out_lvl  (out_lvl)
    );

    // sources: every 1, 2, 3 and 5 reference cycles, changed just after the edge
    always @(posedge clk) begin
        #1;
        fc = fc + 1;
        src_tick[0] = 1'b1;
        src_tick[1] = (fc % 2 == 0);
        src_tick[2] = (fc % 3 == 0);
        src_tick[3] = (fc % 5 == 0);
    end

    function automatic logic [31:0] mk(input bit en, input int sel, input int p, input int m);
        logic [31:0] w;
        w = '0;
        w[31]    = en;
        w[25:24] = sel[1:0];
        w[17:16] = p[1:0];
        w[3:0]   = m[3:0];
        return w;
    endfunction

    task automatic chk(input bit ok, input string rq, input longint a, input longint e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, a, e);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ce();
        int g = 0;
        while (!out_ce && g < 4000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic meas(output int n);
        wait_ce();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!out_ce && n < 4000);
    endtask

    task automatic first_pulse(output int n);
        n = 1;
        while (!out_ce && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);
        chk(out_ce == 1'b0, "R1 out_ce", out_ce, 0);
        chk(out_lvl == 1'b0, "R1 out_lvl", out_lvl, 0);
    endtask

    task automatic t_regmap();
        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'h8303_000F, "R2 all ones", rd_data, 32'h8303_000F);
        wr(32'h0102_0005 | 32'h4000_8000);
        chk(rd_data == 32'h0102_0005, "R2 fields", rd_data, 32'h0102_0005);
    endtask

    task automatic t_sources();
        int n;
        int per [4] = '{2, 4, 6, 10};
        for (int k = 0; k < 4; k++) begin
            wr(mk(1, k, 0, 1));
            meas(n);
            meas(n);
            chk(n == per[k], $sformatf("R4 source %0d", k), n, per[k]);
        end
    endtask

    task automatic t_prediv();
        int n;
        for (int p = 0; p < 4; p++) begin
            wr(mk(1, 0, p, 0));
            meas(n);
            meas(n);
            chk(n == (1 << p), $sformatf("R5 P=%0d", p), n, 1 << p);
        end
        wr(mk(1, 1, 2, 2));
        meas(n);
        meas(n);
        chk(n == 24, "R5 R6 src1 P=2 M=2", n, 24);
    endtask

    task automatic t_mdiv();
        int n;
        wr(mk(1, 0, 0, 15));
        meas(n);
        meas(n);
        chk(n == 16, "R6 M=15", n, 16);
        wr(mk(1, 0, 0, 6));
        meas(n);
        meas(n);
        chk(n == 7, "R6 M=6", n, 7);
    endtask

    task automatic t_duty(input int p, input int m, input int exp_hi);
        int n;
        int h = 0;
        int t = (m + 1) << p;
        wr(mk(1, 0, p, m));
        meas(n);
        for (int i = 0; i < t; i++) begin
            @(negedge clk);
            if (out_lvl) h++;
        end
        chk(h == exp_hi, $sformatf("R7 duty P=%0d M=%0d", p, m), h, exp_hi);
    endtask

    task automatic t_disable();
        int seen = 0;
        wr(mk(1, 0, 0, 1));
        wait_ce();
        wr(mk(0, 0, 0, 1));
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (out_ce || out_lvl) seen++;
        end
        chk(seen == 0, "R3 quiet while disabled", seen, 0);
    endtask

    task automatic t_first();
        int n;
        wr(mk(0, 0, 0, 0));
        wr(mk(1, 0, 0, 4));
        first_pulse(n);
        chk(n == 5, "R9 first pulse M=4", n, 5);
        wr(mk(0, 0, 0, 0));
        wr(mk(1, 0, 2, 2));
        first_pulse(n);
        chk(n == 12, "R9 first pulse P=2 M=2", n, 12);
        // stop part-way through a long period, then restart
        wr(mk(1, 0, 0, 9));
        wait_ce();
        repeat (4) @(negedge clk);
        wr(mk(0, 0, 0, 9));
        wr(mk(1, 0, 0, 4));
        first_pulse(n);
        chk(n == 5, "R3 R9 restart clears counters", n, 5);
    endtask

    task automatic t_glitch();
        int cnt = 0;
        int n;
        wr(mk(1, 0, 0, 9));
        wait_ce();
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 3) begin
                wr_en = 1'b1;
                wr_data = mk(1, 0, 0, 3);
            end else if (cnt == 4) begin
                wr_en = 1'b0;
            end
        end while (!out_ce && cnt < 4000);
        chk(cnt == 10, "R8 running period keeps old length", cnt, 10);
        meas(n);
        chk(n == 4, "R8 next period uses new M", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_disable();
        t_sources();
        t_prediv();
        t_mdiv();
        t_duty(0, 4, 2);
        t_duty(0, 0, 1);
        t_duty(1, 2, 2);
        t_duty(0, 7, 4);
        t_first();
        t_glitch();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule